// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block holds the operating mode of a small microcontroller's clock system and moves it between seven modes. Three are active: high-speed, medium-speed and sub-active (running from the subclock). Four are low-power: sleep, sub-sleep, software standby and watch. A one-cycle sleep request moves the block out of an active mode. The target mode depends on a writable control byte and on two select inputs. A one-cycle wake pulse brings the block back from a low-power mode.

The control byte carries five fields. A direct-transition flag lets a sleep request jump between high-speed and sub-active modes without stopping. A low-speed flag picks the mode entered when watch mode ends. The byte also holds a noise-filter sampling select, a subclock-disable bit and a 2-bit clock multiplier code. Entry into watch or sub-active mode is only allowed from high-speed mode. A request that tries it from medium-speed mode is refused and reported.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (high-speed). illegal_o, clk_sub_o, noise_sel_o, sub_off_o and mult_o are all 0, and both flags are clear.
- R2: A write (wr_en_i=1) loads the control byte. Bit 7 is the direct-transition flag, bit 6 the low-speed flag, bit 5 drives noise_sel_o (0 selects 1/32 sampling, 1 selects 1/4) and bit 4 drives sub_off_o (1 disables the subclock). Bits 1:0 are the multiplier (00 ×1, 01 ×2, 10 ×4). A write carrying multiplier 11 keeps the old multiplier but still updates the other fields. Results show on the edge that takes the write.
- R3: Mode codes are: 0 high-speed, 1 medium-speed, 2 sub-active, 3 sleep, 4 sub-sleep, 5 software standby, 6 watch. In high- or medium-speed mode with no sleep request, the mode follows med_sel_i (1 means medium).
- R4: With the direct flag clear, a sleep request in high- or medium-speed mode goes to sleep if stby_sel_i=0. It goes to standby if stby_sel_i=1 and watch_sel_i=0, and to watch if both selects are 1.
- R5: With the direct flag clear, a sleep request in sub-active mode goes to sub-sleep if stby_sel_i=0 and to watch otherwise.
- R6: With the direct flag set, a sleep request in high- or medium-speed mode goes to sleep, standby or sub-active, decided by the selects as in R4 (both selects at 1 gives sub-active).
- R7: With the direct flag set, a sleep request in sub-active mode goes to sub-sleep if stby_sel_i=0 and straight to high-speed otherwise.
- R8: A wake pulse has these effects:
  - From sleep, the block returns to high- or medium-speed according to med_sel_i.
  - From standby, it returns to high-speed.
  - From sub-sleep, it returns to sub-active.
  - From watch, it returns to sub-active if the low-speed flag is 1 and to high-speed if it is 0.
  - In active modes the wake pulse is ignored. In low-power modes sleep requests are ignored.
- R9: In medium-speed mode, a request that would enter watch or sub-active mode leaves the mode unchanged. illegal_o is then 1 for exactly that one cycle.
- R10: clk_sub_o is 1 exactly when the mode is sub-active, sub-sleep or watch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data |
| sleep_req_i | input | 1 | Sleep request pulse |
| wake_i | input | 1 | Wake-up event pulse |
| stby_sel_i | input | 1 | Selects standby/watch/direct over plain sleep |
| watch_sel_i | input | 1 | Selects watch (or direct) over standby from high/medium speed |
| med_sel_i | input | 1 | Selects medium-speed while in the main-clock active modes |
| mode_o | output | 3 | Current mode code |
| clk_sub_o | output | 1 | Clock source select, 1 = subclock |
| mult_o | output | 2 | Clock multiplier code |
| noise_sel_o | output | 1 | Noise filter sampling select |
| sub_off_o | output | 1 | Subclock disable |
| illegal_o | output | 1 | One-cycle refused-transition flag |

## Verification
Every result of this block is due one clock edge after its stimulus. A sleep request, a wake pulse or a register write is sampled on one rising edge, and mode_o, illegal_o and the control fields carry the result right after that same edge. The driver applies each stimulus at a falling edge and queues one expected record. The monitor pops and compares that record shortly after the next rising edge, so exactly one record is checked per stimulus cycle. The refusal pulse is checked on both sides: high in the refused cycle and low in the following idle cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned MULT_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_HIGH   = 3'd0,
    MODE_MED    = 3'd1,
    MODE_SUB    = 3'd2,
    MODE_SLEEP  = 3'd3,
    MODE_SUBSLP = 3'd4,
    MODE_STBY   = 3'd5,
    MODE_WATCH  = 3'd6
  } mode_e;

  typedef struct packed {
    logic              direct;
    logic              low_spd;
    logic              noise_q;
    logic              sub_off;
    logic [MULT_W-1:0] mult;
  } ctrl_t;

  localparam logic [MULT_W-1:0] MULT_BAD = '1;
endpackage

// File: rtl/lpm_ctrl_reg.sv
module lpm_ctrl_reg
  import lpm_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DIR_BIT  = 7,
  parameter int unsigned LOW_BIT  = 6,
  parameter int unsigned NSE_BIT  = 5,
  parameter int unsigned SUB_BIT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q.direct  <= wr_data_i[DIR_BIT];
      ctrl_q.low_spd <= wr_data_i[LOW_BIT];
      ctrl_q.noise_q <= wr_data_i[NSE_BIT];
      ctrl_q.sub_off <= wr_data_i[SUB_BIT];
      // prohibited multiplier code keeps the previous setting
      if (wr_data_i[MULT_W-1:0] != MULT_BAD)
        ctrl_q.mult <= wr_data_i[MULT_W-1:0];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  sleep_req_i,
  input  logic  wake_i,
  input  logic  stby_sel_i,
  input  logic  watch_sel_i,
  input  logic  med_sel_i,
  output mode_e mode_o,
  output logic  illegal_o
);
  mode_e mode_q, mode_d;
  logic  ill_d, ill_q;

  always_comb begin
    mode_d = mode_q;
    ill_d  = 1'b0;
    case (mode_q)
      MODE_HIGH, MODE_MED: begin
        if (sleep_req_i) begin
          if (!stby_sel_i)       mode_d = MODE_SLEEP;
          else if (!watch_sel_i) mode_d = MODE_STBY;
          else if (mode_q == MODE_MED) ill_d = 1'b1; // watch/sub only from high
          else mode_d = ctrl_i.direct ? MODE_SUB : MODE_WATCH;
        end else begin
          mode_d = med_sel_i ? MODE_MED : MODE_HIGH;
        end
      end
      MODE_SUB: begin
        if (sleep_req_i) begin
          if (!stby_sel_i) mode_d = MODE_SUBSLP;
          else             mode_d = ctrl_i.direct ? MODE_HIGH : MODE_WATCH;
        end
      end
      MODE_SLEEP:  if (wake_i) mode_d = med_sel_i ? MODE_MED : MODE_HIGH;
      MODE_STBY:   if (wake_i) mode_d = MODE_HIGH;
      MODE_SUBSLP: if (wake_i) mode_d = MODE_SUB;
      MODE_WATCH:  if (wake_i) mode_d = ctrl_i.low_spd ? MODE_SUB : MODE_HIGH;
      default:     mode_d = MODE_HIGH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_HIGH;
      ill_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ill_q  <= ill_d;
    end
  end

  assign mode_o    = mode_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sleep_req_i,
  input  logic              wake_i,
  input  logic              stby_sel_i,
  input  logic              watch_sel_i,
  input  logic              med_sel_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              clk_sub_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              noise_sel_o,
  output logic              sub_off_o,
  output logic              illegal_o
);
  ctrl_t ctrl;
  mode_e mode;

  lpm_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl)
  );

  lpm_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .sleep_req_i (sleep_req_i),
    .wake_i      (wake_i),
    .stby_sel_i  (stby_sel_i),
    .watch_sel_i (watch_sel_i),
    .med_sel_i   (med_sel_i),
    .mode_o      (mode),
    .illegal_o   (illegal_o)
  );

  assign mode_o      = mode;
  assign clk_sub_o   = (mode == MODE_SUB) || (mode == MODE_SUBSLP) || (mode == MODE_WATCH);
  assign mult_o      = ctrl.mult;
  assign noise_sel_o = ctrl.noise_q;
  assign sub_off_o   = ctrl.sub_off;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_o,
  input logic              illegal_o,
  input logic [MULT_W-1:0] mult_o,
  input logic              wake_i,
  input logic              sleep_req_i
);
  logic low_pwr;
  assign low_pwr = (mode_o >= 3'(MODE_SLEEP));

  // R9: refused request leaves mode unchanged
  assert_refuse_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(mode_o));

  // R9: refusal only follows a sleep request in medium speed
  assert_refuse_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(illegal_o) |-> ($past(mode_o) == 3'(MODE_MED) && $past(sleep_req_i)));

  // R2: prohibited multiplier never reaches the output
  assert_mult_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_o != MULT_BAD);

  // R4 R5: watch entered only from high-speed or sub-active
  assert_watch_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'(MODE_WATCH) && $past(mode_o) != 3'(MODE_WATCH))
      |-> ($past(mode_o) == 3'(MODE_HIGH) || $past(mode_o) == 3'(MODE_SUB)));

  // R6 R8: sub-active entered only from high-speed, watch or sub-sleep
  assert_sub_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'(MODE_SUB) && $past(mode_o) != 3'(MODE_SUB))
      |-> ($past(mode_o) == 3'(MODE_HIGH) || $past(mode_o) == 3'(MODE_WATCH)
           || $past(mode_o) == 3'(MODE_SUBSLP)));

  // R8: a low-power mode is left only on a wake pulse
  assert_wake_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(low_pwr) && !$stable(mode_o)) |-> $past(wake_i));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_o      (mode_o),
  .illegal_o   (illegal_o),
  .mult_o      (mult_o),
  .wake_i      (wake_i),
  .sleep_req_i (sleep_req_i)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       sleep_req_i = 1'b0, wake_i = 1'b0;
  logic       stby_sel_i = 1'b0, watch_sel_i = 1'b0, med_sel_i = 1'b0;
  logic [2:0] mode_o;
  logic       clk_sub_o, noise_sel_o, sub_off_o, illegal_o;
  logic [1:0] mult_o;

  typedef struct {
    logic [2:0] mode;
    logic       ill;
    logic [1:0] mult;
    logic       noise;
    logic       suboff;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  logic [1:0] e_mult = 2'd0;
  logic e_noise = 1'b0, e_suboff = 1'b0;
  logic [2:0] e_mode = 3'd0;
  bit done = 0;

  lpm_ctrl u_lpm_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .sleep_req_i, .wake_i,
    .stby_sel_i, .watch_sel_i, .med_sel_i, .mode_o, .clk_sub_o,
    .mult_o, .noise_sel_o, .sub_off_o, .illegal_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // R10: subclock select derived from expected mode
  function automatic logic sub_of(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd4) || (m == 3'd6);
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  task automatic push(input logic ill, input string tag);
    exp_t e;
    e.mode = e_mode; e.ill = ill; e.mult = e_mult;
    e.noise = e_noise; e.suboff = e_suboff; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // one stimulus cycle on mode inputs
  task automatic go(input logic slp, input logic wk, input logic sb, input logic wt,
                    input logic md, input logic [2:0] em, input logic eil, input string tag);
    @(negedge clk_i);
    sleep_req_i = slp; wake_i = wk; stby_sel_i = sb; watch_sel_i = wt;
    med_sel_i = md; wr_en_i = 1'b0;
    e_mode = em;
    push(eil, tag);
    @(negedge clk_i);
    sleep_req_i = 1'b0; wake_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic [1:0] em, input string tag);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    if (d[1:0] != 2'b11) e_mult = d[1:0];
    else e_mult = em;
    e_noise = d[5]; e_suboff = d[4];
    push(1'b0, tag);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (mode_o !== e.mode) fail(e.tag, "mode", int'(mode_o), int'(e.mode));
        if (clk_sub_o !== sub_of(e.mode)) fail(e.tag, "clk_sub", int'(clk_sub_o), int'(sub_of(e.mode)));
        if (illegal_o !== e.ill) fail(e.tag, "illegal", int'(illegal_o), int'(e.ill));
        if (mult_o !== e.mult) fail(e.tag, "mult", int'(mult_o), int'(e.mult));
        if (noise_sel_o !== e.noise) fail(e.tag, "noise", int'(noise_sel_o), int'(e.noise));
        if (sub_off_o !== e.suboff) fail(e.tag, "sub_off", int'(sub_off_o), int'(e.suboff));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    n_chk++;
    if (mode_o !== 3'd0 || illegal_o !== 1'b0 || clk_sub_o !== 1'b0 ||
        mult_o !== 2'd0 || noise_sel_o !== 1'b0 || sub_off_o !== 1'b0)
      fail("R1", "reset", int'({mode_o, illegal_o, clk_sub_o, mult_o, noise_sel_o, sub_off_o}), 0);

    // R3 speed select
    go(0,0,0,0,1, 3'd1, 0, "R3 med");
    go(0,0,0,0,0, 3'd0, 0, "R3 high");
    // R4 direct clear from high
    go(1,0,0,0,0, 3'd3, 0, "R4 sleep");
    go(1,0,0,0,0, 3'd3, 0, "R8 sleep req ignored");
    go(0,1,0,0,0, 3'd0, 0, "R8 wake sleep");
    go(1,0,1,0,0, 3'd5, 0, "R4 standby");
    go(0,1,0,0,0, 3'd0, 0, "R8 wake standby");
    go(1,0,1,1,0, 3'd6, 0, "R4 watch");
    go(0,1,0,0,0, 3'd0, 0, "R8 watch low0");
    // low-speed flag
    wr(8'h40, 2'd0, "R2 low flag");
    go(1,0,1,1,0, 3'd6, 0, "R4 watch 2");
    go(0,1,0,0,0, 3'd2, 0, "R8 watch low1");
    go(0,1,0,0,0, 3'd2, 0, "R8 wake ignored active");
    go(1,0,0,0,0, 3'd4, 0, "R5 subsleep");
    go(0,1,0,0,0, 3'd2, 0, "R8 wake subsleep");
    go(1,0,1,0,0, 3'd6, 0, "R5 watch from sub");
    go(0,1,0,0,0, 3'd2, 0, "R8 watch back sub");
    // direct flag set
    wr(8'hC0, 2'd0, "R2 direct flag");
    go(1,0,1,0,0, 3'd0, 0, "R7 sub to high");
    go(1,0,1,1,0, 3'd2, 0, "R6 high to sub");
    go(1,0,0,0,0, 3'd4, 0, "R7 subsleep");
    go(0,1,0,0,0, 3'd2, 0, "R8 wake subsleep 2");
    go(1,0,1,1,0, 3'd0, 0, "R7 sub to high 2");
    go(1,0,0,0,0, 3'd3, 0, "R6 sleep");
    go(0,1,0,0,1, 3'd1, 0, "R8 wake to med");
    go(1,0,1,0,1, 3'd5, 0, "R6 standby from med");
    go(0,1,0,0,1, 3'd0, 0, "R8 standby to high");
    go(0,0,0,0,1, 3'd1, 0, "R3 med 2");
    go(1,0,1,1,1, 3'd1, 1, "R9 med to sub refused");
    go(0,0,0,0,1, 3'd1, 0, "R9 pulse one cycle");
    wr(8'h00, 2'd0, "R2 clear flags");
    go(1,0,1,1,1, 3'd1, 1, "R9 med to watch refused");
    go(0,0,0,0,1, 3'd1, 0, "R9 pulse cleared");
    // R2 field writes
    wr(8'h32, 2'd2, "R2 fields");
    wr(8'h13, 2'd2, "R2 mult 11 kept");
    wr(8'h01, 2'd1, "R2 mult x2");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule